// File: doc/BRIEF.md
# Serial Memory Read Front End

This block is the slave side of a four-wire serial port in front of a 512-byte on-chip memory. It oversamples the serial clock, the active-low select and the serial data input with the system clock. It shifts commands in most significant bit first and decodes the 8-bit command code. It serves array reads on its own. Reads start from a 16-bit address and keep going byte after byte, with the address stepping up by one and wrapping at the top of the array, until the select is released. The serial output changes only in the system cycle that follows a detected falling edge of the serial clock. The output enable is asserted only while a transfer is open.

It also holds the write-enable flag. Command 06h sets the flag, but only when the select is released right after the eighth bit of that command. Command 04h clears the flag at once. Status reads replay a status byte supplied by the neighbouring status block, over and over. For the write commands, the block passes the code, the assembled address, the data bytes and an end-of-transfer marker to the separate programming and status blocks, and those blocks load the array through a plain write port. After reset, a select that is already low is ignored. A transfer opens only on a high-to-low edge of the select.

Top module: `sflash_rd_frontend`

## Requirements
- R1: Serial input bits are taken on rising serial-clock edges, most significant bit first. The eighth bit completes the command code. Recognised codes are 03h (array read), 02h (program), 05h (status read), 01h (status write), 06h (enable set) and 04h (enable clear). A recognised code is presented on `cmd_op_o` with a one-cycle `cmd_valid_o` pulse.
- R2: The array read (03h) is followed by a 16-bit address. Only address bits 8:0 select the first byte, and bits 15:9 are ignored. The first data bit (bit 7) appears on the serial output after the falling serial-clock edge that follows the last address bit. Each data byte is sent most significant bit first.
- R3: After each 8 output bits, the read address steps up by one. The step after 1FFh goes to 000h, and the read continues for as long as the serial clock runs.
- R4: The output enable is low while the select is high. It is high while a transfer is open.
- R5: After reset, no transfer opens until a high-to-low edge of the select is seen. A select held low through reset release does not start a transfer.
- R6: The write-enable flag is set only when the select rises directly after the eighth bit of 06h. Any further serial-clock rising edge before the rise cancels the set.
- R7: The write-enable flag is cleared by reset, by the completed 04h code, and by a pulse on `wen_clear_i`.
- R8: The serial clock may stop at any level for any time. On restart, the transfer continues from the bit where it stopped.
- R9: A rising select ends any command part way and restarts bit counting. After an unrecognised code, the block pulses nothing and the output stays 0 until the select rises.
- R10: The status read (05h) sends `status_byte_i` most significant bit first. After each eighth bit it sends the byte again.
- R11: Program (02h) passes its 16-bit address on `addr_o` with an `addr_valid_o` pulse. Program and status write (01h) pass each following complete byte with an `rx_valid_o` pulse. At each select rise that ends an open transfer, `xfer_end_o` pulses, and `xfer_whole_o` is 1 exactly when a whole number of bytes was clocked in.
- R12: A write on the array port stores `arr_wdata_i` at `arr_waddr_i`. A later array read returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock, idle low |
| spi_cs_n_i | input | 1 | Active-low select |
| spi_si_i | input | 1 | Serial data in |
| spi_so_o | output | 1 | Serial data out |
| spi_so_en_o | output | 1 | Output driver enable; low means the pad floats |
| status_byte_i | input | 8 | Byte replayed by the status read |
| wen_clear_i | input | 1 | Clears the write-enable flag |
| arr_we_i | input | 1 | Array write strobe |
| arr_waddr_i | input | 9 | Array write address |
| arr_wdata_i | input | 8 | Array write data |
| cmd_valid_o | output | 1 | Pulse: recognised code received |
| cmd_op_o | output | 8 | Last received code |
| addr_valid_o | output | 1 | Pulse: 16-bit address complete |
| addr_o | output | 16 | Last assembled address |
| rx_valid_o | output | 1 | Pulse: data byte received |
| rx_byte_o | output | 8 | Last received data byte |
| xfer_end_o | output | 1 | Pulse: open transfer closed by select rise |
| xfer_whole_o | output | 1 | Closed transfer held whole bytes only |
| wen_o | output | 1 | Write-enable flag |

## Verification
The bench reads across the 1FFh-to-000h boundary. A design that sizes its pointer wrongly or stops at the top would return wrong bytes there. It gives addresses with nonzero upper bits, which expose a decoder that uses the full field. It holds the select low through reset, which catches a design that opens transfers on level rather than edge. It sends 06h both with one extra clock and as seven bits only, to catch a flag that sets on the code alone. It stalls the serial clock in mid-byte, to expose a design that times bits by the system clock. It also checks the first data bit right after the address, which an output one edge late would shift by a bit.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_FIELD_W = 16;

    // command codes: values are decoded on the wire
    localparam logic [BYTE_W-1:0] OP_RD_ARRAY  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_PROGRAM   = 8'h02;
    localparam logic [BYTE_W-1:0] OP_RD_STATUS = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_STATUS = 8'h01;
    localparam logic [BYTE_W-1:0] OP_WEN_SET   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WEN_CLR   = 8'h04;

    typedef enum logic [2:0] {
        ST_CODE   = 3'd0,  // collecting the command code
        ST_ADDR   = 3'd1,  // collecting the address field
        ST_RDATA  = 3'd2,  // streaming array bytes out
        ST_RSTAT  = 3'd3,  // streaming the status byte out
        ST_WDATA  = 3'd4,  // passing write bytes to a neighbour
        ST_ARMED  = 3'd5,  // enable-set code seen, waiting for select rise
        ST_IGNORE = 3'd6   // nothing to do until select rises
    } sfr_state_e;

endpackage

// File: rtl/sfr_pin_sampler.sv
module sfr_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_fall_o,
    output logic cs_n_o,
    output logic si_o
);
    typedef struct packed {
        logic sck;
        logic sck_p;
        logic cs_n;
        logic cs_n_p;
        logic si;
    } pins_t;

    pins_t pin_d, pin_q;

    always_comb begin
        pin_d        = pin_q;
        pin_d.sck    = sck_i;
        pin_d.sck_p  = pin_q.sck;
        pin_d.cs_n   = cs_n_i;
        pin_d.cs_n_p = pin_q.cs_n;
        pin_d.si     = si_i;
    end

    // select history resets low so a select already low at reset is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign sck_rise_o = pin_q.sck & ~pin_q.sck_p;
    assign sck_fall_o = ~pin_q.sck & pin_q.sck_p;
    assign cs_fall_o  = pin_q.cs_n_p & ~pin_q.cs_n;
    assign cs_n_o     = pin_q.cs_n;
    assign si_o       = pin_q.si;

    // R5: a select edge needs the select to have been seen high
    a_r5_fall_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall_o |-> $past(cs_n_i, 2));

endmodule

// File: rtl/sfr_byte_array.sv
module sfr_byte_array #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cell_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = cell_q[raddr_i];

    // R12: a written byte is held in the addressed cell
    a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> cell_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/sfr_cmd_engine.sv
module sfr_cmd_engine
    import sfr_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW         = $clog2(DEPTH),
    localparam int CNT_W      = $clog2(BYTE_W),
    localparam int ADDR_BYTES = ADDR_FIELD_W / BYTE_W,
    localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck_rise_i,
    input  logic                    sck_fall_i,
    input  logic                    cs_fall_i,
    input  logic                    cs_n_i,
    input  logic                    si_i,
    input  logic [BYTE_W-1:0]       status_byte_i,
    input  logic                    wen_clear_i,
    output logic [AW-1:0]           mem_raddr_o,
    input  logic [BYTE_W-1:0]       mem_rdata_i,
    output logic                    so_o,
    output logic                    so_en_o,
    output logic                    cmd_valid_o,
    output logic [BYTE_W-1:0]       cmd_op_o,
    output logic                    addr_valid_o,
    output logic [ADDR_FIELD_W-1:0] addr_o,
    output logic                    rx_valid_o,
    output logic [BYTE_W-1:0]       rx_byte_o,
    output logic                    xfer_end_o,
    output logic                    xfer_whole_o,
    output logic                    wen_o
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [AB_W-1:0]  LAST_ABYT = AB_W'(ADDR_BYTES - 1);

    typedef struct packed {
        sfr_state_e              st;
        logic                    open;
        logic [CNT_W-1:0]        bit_cnt;
        logic [AB_W-1:0]         abyte;
        logic [BYTE_W-1:0]       sh_in;
        logic [BYTE_W-1:0]       op;
        logic [ADDR_FIELD_W-1:0] addr;
        logic [AW-1:0]           rd_ptr;
        logic [BYTE_W-1:0]       sh_out;
        logic [CNT_W-1:0]        out_cnt;
        logic                    so;
        logic                    wen;
        logic                    op_vld;
        logic                    addr_vld;
        logic                    rx_vld;
        logic [BYTE_W-1:0]       rx_byte;
        logic                    end_p;
        logic                    end_whole;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [BYTE_W-1:0]       byte_in;
    logic [ADDR_FIELD_W-1:0] addr_in;
    logic                    last_bit;

    assign byte_in  = {eng_q.sh_in[BYTE_W-2:0], si_i};
    assign addr_in  = {eng_q.addr[ADDR_FIELD_W-2:0], si_i};
    assign last_bit = (eng_q.bit_cnt == LAST_BIT);

    // while the address completes, fetch its first byte; else the next one
    assign mem_raddr_o = (eng_q.st == ST_ADDR) ? addr_in[AW-1:0]
                                               : eng_q.rd_ptr + AW'(1);

    always_comb begin
        eng_d          = eng_q;
        eng_d.op_vld   = 1'b0;
        eng_d.addr_vld = 1'b0;
        eng_d.rx_vld   = 1'b0;
        eng_d.end_p    = 1'b0;

        if (cs_n_i) begin
            if (eng_q.open) begin
                eng_d.end_p     = 1'b1;
                eng_d.end_whole = (eng_q.bit_cnt == '0);
                if (eng_q.st == ST_ARMED) eng_d.wen = 1'b1;
            end
            eng_d.open    = 1'b0;
            eng_d.st      = ST_CODE;
            eng_d.bit_cnt = '0;
            eng_d.abyte   = '0;
            eng_d.out_cnt = '0;
            eng_d.so      = 1'b0;
        end else if (cs_fall_i) begin
            eng_d.open    = 1'b1;
            eng_d.st      = ST_CODE;
            eng_d.bit_cnt = '0;
            eng_d.abyte   = '0;
            eng_d.out_cnt = '0;
            eng_d.so      = 1'b0;
        end else if (eng_q.open && sck_rise_i) begin
            eng_d.sh_in   = byte_in;
            eng_d.bit_cnt = last_bit ? '0 : eng_q.bit_cnt + CNT_W'(1);
            unique case (eng_q.st)
                ST_CODE: begin
                    if (last_bit) begin
                        eng_d.op     = byte_in;
                        eng_d.op_vld = 1'b1;
                        case (byte_in)
                            OP_RD_ARRAY,
                            OP_PROGRAM:   eng_d.st = ST_ADDR;
                            OP_RD_STATUS: begin
                                eng_d.st      = ST_RSTAT;
                                eng_d.sh_out  = status_byte_i;
                                eng_d.out_cnt = '0;
                            end
                            OP_WR_STATUS: eng_d.st = ST_WDATA;
                            OP_WEN_SET:   eng_d.st = ST_ARMED;
                            OP_WEN_CLR: begin
                                eng_d.wen = 1'b0;
                                eng_d.st  = ST_IGNORE;
                            end
                            default: begin
                                eng_d.op_vld = 1'b0;
                                eng_d.st     = ST_IGNORE;
                            end
                        endcase
                    end
                end
                ST_ADDR: begin
                    eng_d.addr = addr_in;
                    if (last_bit) begin
                        eng_d.abyte = eng_q.abyte + AB_W'(1);
                        if (eng_q.abyte == LAST_ABYT) begin
                            eng_d.addr_vld = 1'b1;
                            if (eng_q.op == OP_RD_ARRAY) begin
                                eng_d.st      = ST_RDATA;
                                eng_d.rd_ptr  = addr_in[AW-1:0];
                                eng_d.sh_out  = mem_rdata_i;
                                eng_d.out_cnt = '0;
                            end else begin
                                eng_d.st = ST_WDATA;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (last_bit) begin
                        eng_d.rx_vld  = 1'b1;
                        eng_d.rx_byte = byte_in;
                    end
                end
                ST_ARMED: eng_d.st = ST_IGNORE;
                default: ;
            endcase
        end else if (eng_q.open && sck_fall_i &&
                     (eng_q.st == ST_RDATA || eng_q.st == ST_RSTAT)) begin
            eng_d.so      = eng_q.sh_out[BYTE_W-1];
            eng_d.sh_out  = eng_q.sh_out << 1;
            eng_d.out_cnt = eng_q.out_cnt + CNT_W'(1);
            if (eng_q.out_cnt == LAST_BIT) begin
                eng_d.out_cnt = '0;
                if (eng_q.st == ST_RDATA) begin
                    eng_d.sh_out = mem_rdata_i;
                    eng_d.rd_ptr = eng_q.rd_ptr + AW'(1);
                end else begin
                    eng_d.sh_out = status_byte_i;
                end
            end
        end

        if (wen_clear_i) eng_d.wen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign so_o         = eng_q.so;
    assign so_en_o      = eng_q.open;
    assign cmd_valid_o  = eng_q.op_vld;
    assign cmd_op_o     = eng_q.op;
    assign addr_valid_o = eng_q.addr_vld;
    assign addr_o       = eng_q.addr;
    assign rx_valid_o   = eng_q.rx_vld;
    assign rx_byte_o    = eng_q.rx_byte;
    assign xfer_end_o   = eng_q.end_p;
    assign xfer_whole_o = eng_q.end_whole;
    assign wen_o        = eng_q.wen;

    // R4: a high select turns the output driver off
    a_r4_driver_off: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !so_en_o);

    // R6: the flag only rises in the cycle after the select is seen high
    a_r6_set_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_o) |-> $past(cs_n_i));

    // R7: the clear input always wins
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clear_i |=> !wen_o);

    // R1: code, address and data events never coincide
    a_r1_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, addr_valid_o, rx_valid_o}));

    // R9: an ignored command leaves the output at 0
    a_r9_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_IGNORE) |-> !so_o);

endmodule

// File: rtl/sflash_rd_frontend.sv
module sflash_rd_frontend
    import sfr_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck_i,
    input  logic                    spi_cs_n_i,
    input  logic                    spi_si_i,
    output logic                    spi_so_o,
    output logic                    spi_so_en_o,
    input  logic [BYTE_W-1:0]       status_byte_i,
    input  logic                    wen_clear_i,
    input  logic                    arr_we_i,
    input  logic [AW-1:0]           arr_waddr_i,
    input  logic [BYTE_W-1:0]       arr_wdata_i,
    output logic                    cmd_valid_o,
    output logic [BYTE_W-1:0]       cmd_op_o,
    output logic                    addr_valid_o,
    output logic [ADDR_FIELD_W-1:0] addr_o,
    output logic                    rx_valid_o,
    output logic [BYTE_W-1:0]       rx_byte_o,
    output logic                    xfer_end_o,
    output logic                    xfer_whole_o,
    output logic                    wen_o
);
    logic              sck_rise, sck_fall, cs_fall, cs_n_s, si_s;
    logic [AW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_data;

    sfr_pin_sampler u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (spi_sck_i),
        .cs_n_i     (spi_cs_n_i),
        .si_i       (spi_si_i),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_fall_o  (cs_fall),
        .cs_n_o     (cs_n_s),
        .si_o       (si_s)
    );

    sfr_byte_array #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we_i),
        .waddr_i (arr_waddr_i),
        .wdata_i (arr_wdata_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    sfr_cmd_engine #(.DEPTH(DEPTH)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_rise_i    (sck_rise),
        .sck_fall_i    (sck_fall),
        .cs_fall_i     (cs_fall),
        .cs_n_i        (cs_n_s),
        .si_i          (si_s),
        .status_byte_i (status_byte_i),
        .wen_clear_i   (wen_clear_i),
        .mem_raddr_o   (rd_addr),
        .mem_rdata_i   (rd_data),
        .so_o          (spi_so_o),
        .so_en_o       (spi_so_en_o),
        .cmd_valid_o   (cmd_valid_o),
        .cmd_op_o      (cmd_op_o),
        .addr_valid_o  (addr_valid_o),
        .addr_o        (addr_o),
        .rx_valid_o    (rx_valid_o),
        .rx_byte_o     (rx_byte_o),
        .xfer_end_o    (xfer_end_o),
        .xfer_whole_o  (xfer_whole_o),
        .wen_o         (wen_o)
    );

endmodule

// File: tb/sflash_rd_frontend_tb.sv
module sflash_rd_frontend_tb;

    localparam int HALF = 4;   // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b0, si = 1'b0;
    logic        so, so_en;
    logic [7:0]  status_b = 8'h00;
    logic        wen_clear = 1'b0;
    logic        we = 1'b0;
    logic [8:0]  waddr = '0;
    logic [7:0]  wdata = '0;
    logic        cmd_valid, addr_valid, rx_valid, xfer_end, xfer_whole, wen;
    logic [7:0]  cmd_op, rx_byte;
    logic [15:0] addr;

    int n_tests = 0, n_fail = 0;
    int n_cmd = 0, n_addr = 0, n_rx = 0, n_end = 0;
    logic [7:0]  last_cmd = '0, last_rx = '0;
    logic [15:0] last_addr = '0;
    logic        last_whole = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sflash_rd_frontend u_dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_si_i(si),
        .spi_so_o(so), .spi_so_en_o(so_en),
        .status_byte_i(status_b), .wen_clear_i(wen_clear),
        .arr_we_i(we), .arr_waddr_i(waddr), .arr_wdata_i(wdata),
        .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
        .addr_valid_o(addr_valid), .addr_o(addr),
        .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
        .xfer_end_o(xfer_end), .xfer_whole_o(xfer_whole), .wen_o(wen)
    );

    always @(negedge clk) begin
        if (cmd_valid)  begin n_cmd++;  last_cmd  = cmd_op;  end
        if (addr_valid) begin n_addr++; last_addr = addr;    end
        if (rx_valid)   begin n_rx++;   last_rx   = rx_byte; end
        if (xfer_end)   begin n_end++;  last_whole = xfer_whole; end
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF); cs_n = 1'b1; wait_clk(3 * HALF);
    endtask

    task automatic bit_xfer(input logic b, output logic o, input int pause);
        @(negedge clk); si = b;
        wait_clk(HALF);
        o = so;
        sck = 1'b1;
        wait_clk(HALF + pause);
        sck = 1'b0;
    endtask

    task automatic byte_xfer(input logic [7:0] din, output logic [7:0] dout, input int pause);
        for (int k = 7; k >= 0; k--) begin
            logic ob;
            bit_xfer(din[k], ob, (k == 4) ? pause : 0);
            dout[k] = ob;
        end
    endtask

    // table: {address field, byte count}
    localparam logic [23:0] RD_VEC [5] = '{
        {16'h0000, 8'd3},
        {16'h01FE, 8'd4},
        {16'hFE05, 8'd2},
        {16'h0133, 8'd2},
        {16'h01FF, 8'd2}
    };

    initial begin
        logic [7:0] rb;
        logic       ob;
        int         c0;

        // R5: select low through reset release opens nothing
        wait_clk(5); rst_n = 1'b1; wait_clk(3);
        check(so_en == 1'b0 && wen == 1'b0, "R5 R7 reset state", {so_en, wen}, 0);
        byte_xfer(8'h03, rb, 0);
        byte_xfer(8'h00, rb, 0);
        check(so_en == 1'b0, "R5 no open without select edge", so_en, 0);
        check(n_cmd == 0, "R5 no command without select edge", n_cmd, 0);
        desel();

        // R12: load the array through the write port
        for (int i = 0; i < 512; i++) begin
            @(negedge clk); we = 1'b1; waddr = 9'(i); wdata = pat(i);
        end
        @(negedge clk); we = 1'b0;

        // R2 R3 R12: table walk of array reads
        foreach (RD_VEC[v]) begin
            int a0;
            a0 = int'(RD_VEC[v][23:8]) % 512;
            sel();
            check(so_en == 1'b1, "R4 driver on while selected", so_en, 1);
            byte_xfer(8'h03, rb, 0);
            byte_xfer(RD_VEC[v][23:16], rb, 0);
            byte_xfer(RD_VEC[v][15:8], rb, 0);
            check(last_cmd == 8'h03, "R1 read code decoded", last_cmd, 8'h03);
            for (int b = 0; b < int'(RD_VEC[v][7:0]); b++) begin
                byte_xfer(8'h00, rb, 0);
                check(rb == pat((a0 + b) % 512), "R2 R3 read byte", rb, pat((a0 + b) % 512));
            end
            desel();
            check(so_en == 1'b0, "R4 driver off after release", so_en, 0);
        end

        // R8: stalled serial clock mid-byte
        sel();
        byte_xfer(8'h03, rb, 300);
        byte_xfer(8'h00, rb, 0);
        byte_xfer(8'h42, rb, 300);
        byte_xfer(8'h00, rb, 300);
        check(rb == pat(16'h42), "R8 stalled clock read", rb, pat(16'h42));
        desel();

        // R6: set by 06h and a prompt release
        sel(); byte_xfer(8'h06, rb, 0); desel();
        check(wen == 1'b1, "R6 enable set", wen, 1);
        // R7: cleared by 04h
        sel(); byte_xfer(8'h04, rb, 0); desel();
        check(wen == 1'b0, "R7 enable cleared by code", wen, 0);
        // R6: one extra clock cancels the set
        sel(); byte_xfer(8'h06, rb, 0); bit_xfer(1'b0, ob, 0); desel();
        check(wen == 1'b0, "R6 extra clock cancels set", wen, 0);
        // R6: seven bits only
        sel();
        for (int k = 7; k >= 1; k--) bit_xfer(k == 1 || k == 2, ob, 0);
        desel();
        check(wen == 1'b0, "R6 short code no set", wen, 0);
        // R7: clear input
        sel(); byte_xfer(8'h06, rb, 0); desel();
        @(negedge clk); wen_clear = 1'b1; @(negedge clk); wen_clear = 1'b0;
        wait_clk(2);
        check(wen == 1'b0, "R7 clear input", wen, 0);

        // R9: unknown code ignored
        c0 = n_cmd;
        sel(); byte_xfer(8'hA5, rb, 0); byte_xfer(8'hFF, rb, 0);
        check(rb == 8'h00, "R9 output quiet after unknown code", rb, 0);
        check(so_en == 1'b1, "R4 driver on during ignored command", so_en, 1);
        desel();
        check(n_cmd == c0, "R9 unknown code not reported", n_cmd, c0);
        // R9: abort part way, then a fresh read works
        c0 = n_addr;
        sel(); byte_xfer(8'h03, rb, 0); byte_xfer(8'h01, rb, 0); desel();
        check(n_addr == c0, "R9 aborted address not reported", n_addr, c0);
        sel(); byte_xfer(8'h03, rb, 0); byte_xfer(8'h00, rb, 0); byte_xfer(8'h05, rb, 0);
        byte_xfer(8'h00, rb, 0); desel();
        check(rb == pat(5), "R9 read after abort", rb, pat(5));

        // R10: status byte replayed
        status_b = 8'h5A;
        sel(); byte_xfer(8'h05, rb, 0); byte_xfer(8'h00, rb, 0);
        check(rb == 8'h5A, "R10 status first byte", rb, 8'h5A);
        byte_xfer(8'h00, rb, 0);
        check(rb == 8'h5A, "R10 status repeated", rb, 8'h5A);
        desel();

        // R11: program forwards address and bytes
        c0 = n_rx;
        sel(); byte_xfer(8'h02, rb, 0); byte_xfer(8'h80, rb, 0); byte_xfer(8'h10, rb, 0);
        byte_xfer(8'hA5, rb, 0); byte_xfer(8'h3C, rb, 0); desel();
        check(last_cmd == 8'h02, "R11 program code", last_cmd, 8'h02);
        check(last_addr == 16'h8010, "R11 program address", last_addr, 16'h8010);
        check(n_rx == c0 + 2 && last_rx == 8'h3C, "R11 program bytes", last_rx, 8'h3C);
        check(last_whole == 1'b1, "R11 whole-byte end", last_whole, 1);
        // R11: status write with a ragged end
        sel(); byte_xfer(8'h01, rb, 0); byte_xfer(8'h07, rb, 0);
        for (int k = 0; k < 3; k++) bit_xfer(1'b0, ob, 0);
        desel();
        check(last_rx == 8'h07, "R11 status write byte", last_rx, 8'h07);
        check(last_whole == 1'b0, "R11 ragged end flagged", last_whole, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule